// File: doc/BRIEF.md
# Trap and Debug-Halt Controller

This block sits at the commit point of a small RISC-V style core and decides what happens to each instruction that reaches it. It receives five exception sources for that instruction: fetch bus error, illegal encoding, breakpoint instruction, misaligned memory access and data bus error. It chooses the highest-priority source and, if a trap is taken, redirects the pipeline to the trap vector in the same cycle. It also records the faulting PC, the cause code and the trap value in registers it owns, and it handles the trap-return instruction.

A small request/response debug command port drives a four-state machine: RUN, HALT_PEND, HALTED and STEP. The port can halt the core, resume it, single-step it, read its status, and inject one instruction into the pipeline while the core is halted. The first request of any kind on this port sets a sticky attached flag. Once that flag is set, a breakpoint instruction halts the core instead of trapping. No other exception ever halts it.

State transitions: RUN goes to HALT_PEND on a halt command, or straight to HALTED on a breakpoint while attached. HALT_PEND goes to HALTED at the next instruction boundary or on an attached breakpoint. HALTED goes to RUN on resume and to STEP on step. STEP goes back to HALTED after the next instruction is presented at commit.

Top module: `trap_halt_ctrl`

## Requirements
- R1: After reset the core is running and not halted, the attached flag is clear, the interrupt-enable bit equals the MIE_RST parameter (default 1), the exception PC, cause and trap value are zero, and no redirect or debug acknowledge is driven.
- R2: Cause codes are: fetch bus error 1, illegal instruction 2, breakpoint 3, misaligned load 4, data bus error on a load 5, misaligned store 6, data bus error on a store 7. When several sources are raised together, the winner is taken in this order: fetch error, illegal, breakpoint, misaligned, data bus error.
- R3: An access is misaligned only when mem_req is high and either mem_size is 01 (halfword) with address bit 0 set, or mem_size is 10 or 11 (word) with either of the two low address bits set. Byte accesses (00) are never misaligned. A data bus error counts only when mem_req is high.
- R4: When a trap is taken, redirect_valid is high in the same cycle and redirect_pc equals tvec_base with its two low bits cleared. From the next cycle, epc_q holds ex_pc and trap_cause holds the code. tval_q holds ex_pc for a fetch error or breakpoint, the instruction word for an illegal instruction, and mem_addr for misaligned or bus-error accesses.
- R5: A trap copies the interrupt-enable bit to a saved copy and clears it. A trap return (ex_mret with no exception) redirects to epc_q in the same cycle, restores the interrupt-enable bit from the saved copy, and sets the saved copy to 1.
- R6: The attached flag is set by any debug request and stays set until reset.
- R7: While attached, a winning breakpoint halts the core on the next cycle. No redirect is driven and the cause, exception PC and trap value are left unchanged. While not attached, a breakpoint traps with code 3.
- R8: No exception other than a breakpoint ever halts the core, whether or not the debugger is attached.
- R9: A halt command (dbg_cmd 1) moves the core to a pending state. It halts on the cycle after the first cycle in which boundary is high. Instructions presented while the halt is pending are still processed.
- R10: While halted, commit and exception inputs are ignored: there is no redirect and no register changes.
- R11: Resume (dbg_cmd 2) returns a halted core to running. Step (dbg_cmd 3) lets exactly one presented instruction through, including any trap it raises, and then halts again.
- R12: Inject (dbg_cmd 4) with dbg_data is accepted only while halted. inj_valid is then high for one cycle on the next cycle, with inj_instr equal to dbg_data. In any other state, inject has no effect on inj_valid.
- R13: Every debug request is acknowledged by dbg_ack on the next cycle. dbg_ok is 1 for status (dbg_cmd 0) and halt. It is 1 for resume, step and inject only when the core is halted, and 0 for codes 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ex_valid | input | 1 | An instruction is at commit this cycle |
| ex_pc | input | XLEN | PC of that instruction |
| ex_instr | input | ILEN | Instruction word |
| ex_fetch_err | input | 1 | Fetch returned a bus error |
| ex_illegal | input | 1 | Illegal instruction |
| ex_ebreak | input | 1 | Breakpoint instruction |
| ex_mret | input | 1 | Trap-return instruction |
| mem_req | input | 1 | Instruction performs a memory access |
| mem_store | input | 1 | Access is a store |
| mem_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| mem_addr | input | XLEN | Access address |
| mem_bus_err | input | 1 | Data bus returned an error |
| boundary | input | 1 | Pipeline is at an instruction boundary |
| tvec_base | input | XLEN | Trap-vector base register value |
| dbg_req | input | 1 | Debug command request |
| dbg_cmd | input | 3 | Debug command code |
| dbg_data | input | ILEN | Instruction for inject |
| redirect_valid | output | 1 | Fetch redirect this cycle |
| redirect_pc | output | XLEN | Redirect target |
| epc_q | output | XLEN | Exception PC register |
| trap_cause | output | 4 | Cause register |
| tval_q | output | XLEN | Trap value register |
| mie | output | 1 | Interrupt-enable bit |
| halted | output | 1 | Stall the pipeline: core halted |
| dbg_attached | output | 1 | Sticky attached flag |
| dbg_ack | output | 1 | Debug response valid |
| dbg_ok | output | 1 | Command accepted |
| inj_valid | output | 1 | Injected instruction valid |
| inj_instr | output | ILEN | Injected instruction |

## Verification
If the state register is corrupted, halted or dbg_ok disagrees with the command history one cycle after the corrupting event. A wrong priority or a wrong misaligned decode shows up as a wrong trap_cause or tval_q on the cycle after the trap. A stuck or mis-set attached flag is exposed by the next breakpoint: it either redirects when it should halt or halts when it should redirect, and both outcomes are visible on the same cycle or the next. A lost saved enable bit appears on mie right after the next trap return.

// File: rtl/trap_halt_pkg.sv
package trap_halt_pkg;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_HALT_PEND = 2'd1,
        ST_HALTED    = 2'd2,
        ST_STEP      = 2'd3
    } dbg_state_e;

    typedef enum logic [2:0] {
        CMD_STATUS = 3'd0,
        CMD_HALT   = 3'd1,
        CMD_RESUME = 3'd2,
        CMD_STEP   = 3'd3,
        CMD_INJECT = 3'd4
    } dbg_cmd_e;

    localparam logic [3:0] CAUSE_FETCH   = 4'd1;
    localparam logic [3:0] CAUSE_ILLEGAL = 4'd2;
    localparam logic [3:0] CAUSE_BKPT    = 4'd3;
    localparam logic [3:0] CAUSE_LD_MIS  = 4'd4;
    localparam logic [3:0] CAUSE_LD_ACC  = 4'd5;
    localparam logic [3:0] CAUSE_ST_MIS  = 4'd6;
    localparam logic [3:0] CAUSE_ST_ACC  = 4'd7;

    // index 0 is the highest priority source
    localparam int NUM_SRC = 5;

endpackage

// File: rtl/trap_prio.sv
module trap_prio
    import trap_halt_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int ILEN = 32
) (
    input  logic            fetch_err,
    input  logic            illegal,
    input  logic            ebreak,
    input  logic            mem_req,
    input  logic            mem_store,
    input  logic [1:0]      mem_size,
    input  logic [XLEN-1:0] mem_addr,
    input  logic            bus_err,
    input  logic [XLEN-1:0] pc,
    input  logic [ILEN-1:0] instr,
    output logic            any,
    output logic [3:0]      code,
    output logic [XLEN-1:0] tval,
    output logic            is_bkpt
);

    logic                misaligned;
    logic [NUM_SRC-1:0]  raw;
    logic [3:0]          src_code [NUM_SRC];
    logic [XLEN-1:0]     src_tval [NUM_SRC];

    always_comb begin
        unique case (mem_size)
            2'b00:   misaligned = 1'b0;
            2'b01:   misaligned = mem_addr[0];
            default: misaligned = |mem_addr[1:0];
        endcase
    end

    assign raw = {mem_req & bus_err, mem_req & misaligned, ebreak, illegal, fetch_err};

    assign src_code[0] = CAUSE_FETCH;
    assign src_code[1] = CAUSE_ILLEGAL;
    assign src_code[2] = CAUSE_BKPT;
    assign src_code[3] = mem_store ? CAUSE_ST_MIS : CAUSE_LD_MIS;
    assign src_code[4] = mem_store ? CAUSE_ST_ACC : CAUSE_LD_ACC;

    assign src_tval[0] = pc;
    assign src_tval[1] = XLEN'(instr);
    assign src_tval[2] = pc;
    assign src_tval[3] = mem_addr;
    assign src_tval[4] = mem_addr;

    // walk from lowest to highest priority so the highest one wins
    always_comb begin
        code = '0;
        tval = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (raw[i]) begin
                code = src_code[i];
                tval = src_tval[i];
            end
        end
        any     = |raw;
        is_bkpt = any && (code == CAUSE_BKPT);
    end

endmodule

// File: rtl/trap_csr_regs.sv
module trap_csr_regs #(
    parameter int   XLEN    = 32,
    parameter logic MIE_RST = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_take,
    input  logic            mret_take,
    input  logic [XLEN-1:0] pc,
    input  logic [3:0]      code,
    input  logic [XLEN-1:0] tval,
    output logic [XLEN-1:0] epc_q,
    output logic [3:0]      cause_q,
    output logic [XLEN-1:0] tval_q,
    output logic            mie_q
);

    logic mpie_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
            tval_q  <= '0;
            mie_q   <= MIE_RST;
            mpie_q  <= 1'b0;
        end else if (trap_take) begin
            epc_q   <= pc;
            cause_q <= code;
            tval_q  <= tval;
            mpie_q  <= mie_q;
            mie_q   <= 1'b0;
        end else if (mret_take) begin
            mie_q   <= mpie_q;
            mpie_q  <= 1'b1;
        end
    end

endmodule

// File: rtl/dbg_ctrl.sv
module dbg_ctrl
    import trap_halt_pkg::*;
#(
    parameter int ILEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dbg_req,
    input  logic [2:0]      dbg_cmd,
    input  logic [ILEN-1:0] dbg_data,
    input  logic            boundary,
    input  logic            instr_done,
    input  logic            bkpt_halt,
    output dbg_state_e      st,
    output logic            attached,
    output logic            ack,
    output logic            ok,
    output logic            inj_valid,
    output logic [ILEN-1:0] inj_instr
);

    dbg_state_e st_nxt;
    logic       halt_cmd, resume_cmd, step_cmd, inject_cmd, cmd_ok;

    assign halt_cmd   = dbg_req && (dbg_cmd == CMD_HALT);
    assign resume_cmd = dbg_req && (dbg_cmd == CMD_RESUME);
    assign step_cmd   = dbg_req && (dbg_cmd == CMD_STEP);
    assign inject_cmd = dbg_req && (dbg_cmd == CMD_INJECT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= st_nxt;
    end

    // transitions
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_RUN: begin
                if (bkpt_halt)     st_nxt = ST_HALTED;
                else if (halt_cmd) st_nxt = ST_HALT_PEND;
            end
            ST_HALT_PEND: begin
                if (bkpt_halt || boundary) st_nxt = ST_HALTED;
            end
            ST_HALTED: begin
                if (resume_cmd)    st_nxt = ST_RUN;
                else if (step_cmd) st_nxt = ST_STEP;
            end
            ST_STEP: begin
                if (instr_done) st_nxt = ST_HALTED;
            end
        endcase
    end

    always_comb begin
        case (dbg_cmd)
            CMD_STATUS, CMD_HALT:             cmd_ok = 1'b1;
            CMD_RESUME, CMD_STEP, CMD_INJECT: cmd_ok = (st == ST_HALTED);
            default:                          cmd_ok = 1'b0;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            attached  <= 1'b0;
            ack       <= 1'b0;
            ok        <= 1'b0;
            inj_valid <= 1'b0;
            inj_instr <= '0;
        end else begin
            attached  <= attached | dbg_req;
            ack       <= dbg_req;
            ok        <= dbg_req && cmd_ok;
            inj_valid <= inject_cmd && (st == ST_HALTED);
            if (inject_cmd) inj_instr <= dbg_data;
        end
    end

endmodule

// File: rtl/trap_halt_ctrl.sv
module trap_halt_ctrl
    import trap_halt_pkg::*;
#(
    parameter int   XLEN    = 32,
    parameter int   ILEN    = 32,
    parameter logic MIE_RST = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ex_valid,
    input  logic [XLEN-1:0] ex_pc,
    input  logic [ILEN-1:0] ex_instr,
    input  logic            ex_fetch_err,
    input  logic            ex_illegal,
    input  logic            ex_ebreak,
    input  logic            ex_mret,
    input  logic            mem_req,
    input  logic            mem_store,
    input  logic [1:0]      mem_size,
    input  logic [XLEN-1:0] mem_addr,
    input  logic            mem_bus_err,
    input  logic            boundary,
    input  logic [XLEN-1:0] tvec_base,
    input  logic            dbg_req,
    input  logic [2:0]      dbg_cmd,
    input  logic [ILEN-1:0] dbg_data,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic [XLEN-1:0] epc_q,
    output logic [3:0]      trap_cause,
    output logic [XLEN-1:0] tval_q,
    output logic            mie,
    output logic            halted,
    output logic            dbg_attached,
    output logic            dbg_ack,
    output logic            dbg_ok,
    output logic            inj_valid,
    output logic [ILEN-1:0] inj_instr
);

    localparam logic [XLEN-1:0] VEC_MASK = ~XLEN'(3);

    dbg_state_e      st;
    logic            exc_any, exc_bkpt;
    logic [3:0]      exc_code;
    logic [XLEN-1:0] exc_tval;
    logic            commit_win, bkpt_halt, trap_take, mret_take;

    trap_prio #(.XLEN(XLEN), .ILEN(ILEN)) u_prio (
        .fetch_err (ex_fetch_err),
        .illegal   (ex_illegal),
        .ebreak    (ex_ebreak),
        .mem_req   (mem_req),
        .mem_store (mem_store),
        .mem_size  (mem_size),
        .mem_addr  (mem_addr),
        .bus_err   (mem_bus_err),
        .pc        (ex_pc),
        .instr     (ex_instr),
        .any       (exc_any),
        .code      (exc_code),
        .tval      (exc_tval),
        .is_bkpt   (exc_bkpt)
    );

    assign commit_win = ex_valid && (st != ST_HALTED);
    assign bkpt_halt  = commit_win && exc_bkpt && dbg_attached;
    assign trap_take  = commit_win && exc_any && !bkpt_halt;
    assign mret_take  = commit_win && !exc_any && ex_mret;

    trap_csr_regs #(.XLEN(XLEN), .MIE_RST(MIE_RST)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .trap_take (trap_take),
        .mret_take (mret_take),
        .pc        (ex_pc),
        .code      (exc_code),
        .tval      (exc_tval),
        .epc_q     (epc_q),
        .cause_q   (trap_cause),
        .tval_q    (tval_q),
        .mie_q     (mie)
    );

    dbg_ctrl #(.ILEN(ILEN)) u_dbg (
        .clk        (clk),
        .rst_n      (rst_n),
        .dbg_req    (dbg_req),
        .dbg_cmd    (dbg_cmd),
        .dbg_data   (dbg_data),
        .boundary   (boundary),
        .instr_done (commit_win),
        .bkpt_halt  (bkpt_halt),
        .st         (st),
        .attached   (dbg_attached),
        .ack        (dbg_ack),
        .ok         (dbg_ok),
        .inj_valid  (inj_valid),
        .inj_instr  (inj_instr)
    );

    always_comb begin
        redirect_valid = trap_take || mret_take;
        if (trap_take)      redirect_pc = tvec_base & VEC_MASK;
        else if (mret_take) redirect_pc = epc_q;
        else                redirect_pc = '0;
        halted = (st == ST_HALTED);
    end

endmodule

// File: rtl/trap_halt_ctrl_chk.sv
module trap_halt_ctrl_chk
    import trap_halt_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ex_valid,
    input logic            ex_ebreak,
    input logic            ex_fetch_err,
    input logic            ex_illegal,
    input logic [XLEN-1:0] ex_pc,
    input logic            dbg_req,
    input logic            dbg_attached,
    input logic            dbg_ack,
    input logic            halted,
    input logic            redirect_valid,
    input logic            inj_valid,
    input logic            boundary,
    input dbg_state_e      st,
    input logic            trap_take,
    input logic            bkpt_halt,
    input logic            mie,
    input logic [XLEN-1:0] epc_q
);

    a_r10_no_redirect_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !redirect_valid);

    a_r6_attach_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |=> dbg_attached);

    a_r6_attached_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_attached |=> dbg_attached);

    a_r13_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_req |=> dbg_ack);

    a_r13_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_req |=> !dbg_ack);

    a_r8_only_bkpt_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && !dbg_req && !ex_ebreak) |=> !halted);

    a_r7_bkpt_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && ex_valid && ex_ebreak && !ex_fetch_err && !ex_illegal && dbg_attached)
        |=> halted);

    a_r7_bkpt_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        bkpt_halt |-> !redirect_valid);

    a_r9_wait_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT_PEND && !boundary && !bkpt_halt) |=> !halted);

    a_r4_epc_saved: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> epc_q == $past(ex_pc));

    a_r5_trap_clears_mie: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> !mie);

    a_r12_inject_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |-> halted);

endmodule

bind trap_halt_ctrl trap_halt_ctrl_chk #(.XLEN(XLEN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ex_valid       (ex_valid),
    .ex_ebreak      (ex_ebreak),
    .ex_fetch_err   (ex_fetch_err),
    .ex_illegal     (ex_illegal),
    .ex_pc          (ex_pc),
    .dbg_req        (dbg_req),
    .dbg_attached   (dbg_attached),
    .dbg_ack        (dbg_ack),
    .halted         (halted),
    .redirect_valid (redirect_valid),
    .inj_valid      (inj_valid),
    .boundary       (boundary),
    .st             (st),
    .trap_take      (trap_take),
    .bkpt_halt      (bkpt_halt),
    .mie            (mie),
    .epc_q          (epc_q)
);

// File: tb/trap_halt_ctrl_test.sv
module trap_halt_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ex_valid, ex_fetch_err, ex_illegal, ex_ebreak, ex_mret;
    logic [31:0] ex_pc, ex_instr;
    logic        mem_req, mem_store, mem_bus_err, boundary;
    logic [1:0]  mem_size;
    logic [31:0] mem_addr, tvec_base;
    logic        dbg_req;
    logic [2:0]  dbg_cmd;
    logic [31:0] dbg_data;
    logic        redirect_valid, mie, halted, dbg_attached, dbg_ack, dbg_ok, inj_valid;
    logic [31:0] redirect_pc, epc_q, tval_q, inj_instr;
    logic [3:0]  trap_cause;

    always #2 clk = ~clk;

    trap_halt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_pc(ex_pc), .ex_instr(ex_instr),
        .ex_fetch_err(ex_fetch_err), .ex_illegal(ex_illegal), .ex_ebreak(ex_ebreak),
        .ex_mret(ex_mret), .mem_req(mem_req), .mem_store(mem_store), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_bus_err(mem_bus_err), .boundary(boundary),
        .tvec_base(tvec_base), .dbg_req(dbg_req), .dbg_cmd(dbg_cmd), .dbg_data(dbg_data),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .epc_q(epc_q),
        .trap_cause(trap_cause), .tval_q(tval_q), .mie(mie), .halted(halted),
        .dbg_attached(dbg_attached), .dbg_ack(dbg_ack), .dbg_ok(dbg_ok),
        .inj_valid(inj_valid), .inj_instr(inj_instr)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state: 0 run, 1 halt pending, 2 halted, 3 step
    int          m_st;
    bit          m_att, m_mie, m_mpie;
    logic [31:0] m_epc, m_tval;
    logic [3:0]  m_cause;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] ref_code();
        bit mis;
        mis = mem_req && ((mem_size == 2'b01 && mem_addr[0]) ||
                          (mem_size[1] && mem_addr[1:0] != 2'b00));
        if (ex_fetch_err) return 5'h11;
        if (ex_illegal)   return 5'h12;
        if (ex_ebreak)    return 5'h13;
        if (mis)          return mem_store ? 5'h16 : 5'h14;
        if (mem_req && mem_bus_err) return mem_store ? 5'h17 : 5'h15;
        return 5'h00;
    endfunction

    function automatic logic [31:0] ref_tval(input logic [3:0] c);
        if (c == 4'd1 || c == 4'd3) return ex_pc;
        if (c == 4'd2)              return ex_instr;
        return mem_addr;
    endfunction

    task automatic drive_idle();
        ex_valid = 0; ex_fetch_err = 0; ex_illegal = 0; ex_ebreak = 0; ex_mret = 0;
        mem_req = 0; mem_store = 0; mem_size = 2'b00; mem_bus_err = 0; boundary = 0;
        dbg_req = 0; dbg_cmd = 3'd0;
    endtask

    task automatic model_reset();
        m_st = 0; m_att = 0; m_mie = 1; m_mpie = 0; m_epc = 0; m_tval = 0; m_cause = 0;
    endtask

    task automatic check_regs(input string lbl);
        chk(lbl, "halted", halted, m_st == 2);
        chk(lbl, "attached", dbg_attached, m_att);
        chk(lbl, "epc", epc_q, m_epc);
        chk(lbl, "cause", trap_cause, m_cause);
        chk(lbl, "tval", tval_q, m_tval);
        chk(lbl, "mie", mie, m_mie);
    endtask

    task automatic tick();
        logic [4:0]  rc;
        bit          commit, exc, ebh, trap, mr, e_ack, e_ok, e_inj;
        logic [31:0] e_inj_d;
        int          ns;
        string       rl, hl;
        #1;
        commit = ex_valid && (m_st != 2);
        rc     = ref_code();
        exc    = commit && rc[4];
        ebh    = exc && (rc[3:0] == 4'd3) && m_att;
        trap   = exc && !ebh;
        mr     = commit && !rc[4] && ex_mret;
        rl     = (m_st == 2) ? "R10" : (ebh ? "R7" : (mr ? "R5" : "R4"));
        chk(rl, "redirect_valid", redirect_valid, trap || mr);
        if (trap || mr)
            chk(rl, "redirect_pc", redirect_pc, trap ? (tvec_base & ~32'h3) : m_epc);
        if (trap) begin
            m_epc = ex_pc; m_cause = rc[3:0]; m_tval = ref_tval(rc[3:0]);
            m_mpie = m_mie; m_mie = 0;
        end else if (mr) begin
            m_mie = m_mpie; m_mpie = 1;
        end
        e_ack = dbg_req;
        case (dbg_cmd)
            3'd0, 3'd1:       e_ok = 1;
            3'd2, 3'd3, 3'd4: e_ok = (m_st == 2);
            default:          e_ok = 0;
        endcase
        e_inj   = dbg_req && dbg_cmd == 3'd4 && m_st == 2;
        e_inj_d = dbg_data;
        ns = m_st;
        case (m_st)
            0: if (ebh) ns = 2; else if (dbg_req && dbg_cmd == 3'd1) ns = 1;
            1: if (ebh || boundary) ns = 2;
            2: if (dbg_req && dbg_cmd == 3'd2) ns = 0; else if (dbg_req && dbg_cmd == 3'd3) ns = 3;
            default: if (commit) ns = 2;
        endcase
        if (ebh)            hl = "R7";
        else if (m_st == 1) hl = "R9";
        else if (m_st == 3) hl = "R11";
        else if (m_st == 2) hl = "R10";
        else if (exc)       hl = "R8";
        else                hl = "R9";
        m_att = m_att | dbg_req;
        m_st  = ns;
        @(posedge clk);
        @(negedge clk);
        check_regs(hl);
        chk("R13", "ack", dbg_ack, e_ack);
        if (e_ack) chk("R13", "ok", dbg_ok, e_ok);
        chk("R12", "inj_valid", inj_valid, e_inj);
        if (e_inj) chk("R12", "inj_instr", inj_instr, e_inj_d);
        drive_idle();
    endtask

    task automatic instr(input logic [31:0] pc, input bit fe, input bit il, input bit eb, input bit mr,
                         input bit mq, input bit ms, input logic [1:0] sz, input logic [31:0] ad,
                         input bit be);
        ex_valid = 1; ex_pc = pc; ex_instr = pc ^ 32'hA5A5_0013;
        ex_fetch_err = fe; ex_illegal = il; ex_ebreak = eb; ex_mret = mr;
        mem_req = mq; mem_store = ms; mem_size = sz; mem_addr = ad; mem_bus_err = be;
        tick();
    endtask

    task automatic dbg(input logic [2:0] cmd, input logic [31:0] data);
        dbg_req = 1; dbg_cmd = cmd; dbg_data = data;
        tick();
    endtask

    task automatic rand_cycle(input bit dbg_on);
        ex_valid     = ($urandom % 10) < 6;
        ex_pc        = $urandom & ~32'h3;
        ex_instr     = $urandom;
        ex_fetch_err = ($urandom % 8) == 0;
        ex_illegal   = ($urandom % 8) == 0;
        ex_ebreak    = ($urandom % 8) == 0;
        ex_mret      = ($urandom % 6) == 0;
        mem_req      = ($urandom % 2) == 1;
        mem_store    = ($urandom % 2) == 1;
        mem_size     = 2'($urandom % 4);
        mem_addr     = $urandom;
        mem_bus_err  = ($urandom % 6) == 0;
        boundary     = ($urandom % 2) == 1;
        if (($urandom % 20) == 0) tvec_base = $urandom;
        if (dbg_on && ($urandom % 8) == 0) begin
            dbg_req  = 1;
            dbg_cmd  = 3'($urandom % 6);
            dbg_data = $urandom;
        end
        tick();
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        drive_idle();
        ex_pc = 0; ex_instr = 0; mem_addr = 0; dbg_data = 0; tvec_base = 32'h0000_0103;
        rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check_regs("R1");
        chk("R1", "redirect_valid", redirect_valid, 1'b0);
        chk("R1", "ack", dbg_ack, 1'b0);

        // R4 fetch fault outside memory
        instr(32'h0000_4000, 1, 0, 0, 0, 0, 0, 2'b00, 32'h0, 0);
        // R5 trap return
        instr(32'h0000_0100, 0, 0, 0, 1, 0, 0, 2'b00, 32'h0, 0);
        // R2 priority ladder
        instr(32'h0000_0200, 1, 1, 1, 0, 1, 0, 2'b10, 32'h0000_0003, 1);
        instr(32'h0000_0204, 0, 1, 1, 0, 1, 0, 2'b10, 32'h0000_0003, 1);
        instr(32'h0000_0208, 0, 0, 1, 0, 1, 0, 2'b10, 32'h0000_0003, 1);
        instr(32'h0000_020C, 0, 0, 0, 0, 1, 0, 2'b10, 32'h0000_0003, 1);
        instr(32'h0000_0210, 0, 0, 0, 0, 1, 1, 2'b10, 32'h0000_0008, 1);
        instr(32'h0000_0214, 0, 0, 0, 0, 1, 1, 2'b01, 32'h0000_0011, 0);
        // R3 alignment corners
        instr(32'h0000_0218, 0, 0, 0, 0, 1, 0, 2'b00, 32'h0000_0007, 0);
        instr(32'h0000_021C, 0, 0, 0, 0, 1, 0, 2'b01, 32'h0000_0002, 0);
        instr(32'h0000_0220, 0, 0, 0, 0, 1, 0, 2'b11, 32'h0000_0002, 0);
        instr(32'h0000_0224, 0, 0, 0, 0, 0, 0, 2'b10, 32'h0000_0001, 1);

        for (int i = 0; i < 400; i++) rand_cycle(0);

        // R6 attach through status read
        dbg(3'd0, 32'h0);
        // R13 resume and inject while running are refused; R12 no inject output
        dbg(3'd2, 32'h0);
        dbg(3'd4, 32'h1234_5678);
        // R7 breakpoint halts
        instr(32'h0000_0300, 0, 0, 1, 0, 0, 0, 2'b00, 32'h0, 0);
        // R10 inputs ignored while halted
        instr(32'h0000_0304, 1, 0, 0, 0, 0, 0, 2'b00, 32'h0, 0);
        instr(32'h0000_0308, 0, 0, 0, 1, 0, 0, 2'b00, 32'h0, 0);
        // R12 inject while halted
        dbg(3'd4, 32'hDEAD_BEEF);
        // R11 step with a misaligned store trap, then step a plain instruction
        dbg(3'd3, 32'h0);
        instr(32'h0000_0400, 0, 0, 0, 0, 1, 1, 2'b10, 32'h0000_0402, 0);
        dbg(3'd3, 32'h0);
        tick();
        instr(32'h0000_0404, 0, 0, 0, 0, 0, 0, 2'b00, 32'h0, 0);
        // R11 resume, then R8 other exceptions do not halt when attached
        dbg(3'd2, 32'h0);
        instr(32'h0000_0500, 0, 1, 0, 0, 0, 0, 2'b00, 32'h0, 0);
        instr(32'h0000_0504, 0, 0, 0, 0, 1, 0, 2'b00, 32'h0000_0600, 1);
        // R9 halt waits for boundary, instructions still processed while pending
        dbg(3'd1, 32'h0);
        instr(32'h0000_0508, 1, 0, 0, 0, 0, 0, 2'b00, 32'h0, 0);
        tick();
        boundary = 1;
        tick();
        dbg(3'd7, 32'h0);
        dbg(3'd2, 32'h0);

        for (int i = 0; i < 800; i++) rand_cycle(1);

        // R6 flag clears only on reset
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        model_reset();
        @(negedge clk);
        check_regs("R6");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule